// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache that sits between a CPU load/store port and a lower-level memory port. It has one way, so every address maps to exactly one line. Each line carries a valid flag, a modified (dirty) flag, a tag and a full block of data. Each CPU address is split into a tag, a line index and a byte offset. A lookup hits when the indexed line is valid and its stored tag equals the tag of the address. A hit completes in the same cycle without a stall.

Stores go only to the cache and mark the line dirty. A store miss first allocates the line and then merges the store into it. On any miss the CPU is held with `cpu_stall_o` until the line is present. A dirty victim is pushed into a small FIFO write buffer as a line address plus data. A clean victim is dropped. The buffer drains to memory whenever the memory port is free, and a line fill always takes the port ahead of a drain. If the missing line is still waiting in the buffer, the line is taken from the buffer and not from memory. The CPU holds its request, address and data steady while stalled. The memory port holds its request until it receives a one-cycle acknowledge.

Top module: `dm_wb_cache`

## Requirements
- R1: With default parameters (64 lines of 16 bytes, 32-bit address), the byte offset is address bits [3:0], the index is bits [9:4] and the tag is bits [31:10]. Two addresses with the same index but different tags evict each other.
- R2: After reset every line is invalid, so the first access to any address stalls and issues a memory read. With no CPU request, stall and memory request are both low.
- R3: A read hit returns the addressed 32-bit word in the cycle it is presented, with `cpu_stall_o` low and no memory traffic. Word w of a line is selected by address bits [3:2] and occupies line bits [32w+31:32w].
- R4: A store hit writes only the bytes whose `cpu_be_i` bit is set (bit b covers data bits [8b+7:8b]), completes without a stall and issues no memory write.
- R5: On a miss the CPU is stalled and exactly one line read is issued at the line-aligned address (offset bits zero). In the cycle after the fill is acknowledged the held access completes as a hit, and later accesses to that line hit.
- R6: A store miss fetches the block and then merges the store into it. Bytes that are not enabled keep the values fetched from memory.
- R7: A dirty victim is later written to memory as one line write of its own line address and data. Evicting a clean victim produces no memory write.
- R8: When a dirty victim must be evicted and the write buffer is full, the CPU stays stalled until a drain write is acknowledged.
- R9: When a fill and a pending drain both want the idle memory port, the fill is issued first.
- R10: A miss whose line is pending in the write buffer is served from the newest matching entry with no memory read.
- R11: While `mem_req_o` is high and not acknowledged, the request, address and direction stay unchanged. During a write the data also stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | CPU access request, held while stalled |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W (32) | Byte address |
| cpu_be_i | input | 4 | Store byte enables |
| cpu_wdata_i | input | 32 | Store data |
| cpu_rdata_o | output | 32 | Load data, valid when request is high and stall is low |
| cpu_stall_o | output | 1 | Access not complete this cycle |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | 1 = line write (drain), 0 = line read (fill) |
| mem_addr_o | output | ADDR_W (32) | Line-aligned memory address |
| mem_wdata_o | output | 8*LINE_BYTES (128) | Line write data |
| mem_rdata_i | input | 8*LINE_BYTES (128) | Line read data, valid with acknowledge |
| mem_ack_i | input | 1 | One-cycle completion of the current request |

## Verification
The hardest state to reach from the ports is a full write buffer meeting a dirty victim. Drains use every idle memory slot, and each ordinary miss costs one memory fill, so the buffer rarely holds more than one entry. The stimulus gets around this with alternating stores to two lines that share an index while memory writes are made very slow. After the first round, each miss is served from the buffer and pushes the other dirty line without touching memory. The buffer then fills in a few cycles, the next eviction has to wait for a drain acknowledge, and both lines must later read back from their newest buffered copies. Random traffic over a few conflicting indexes, with varying memory latency, is checked word by word against a flat-memory model.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [0:0] {
    ST_LOOKUP = 1'b0,
    ST_FILL   = 1'b1
  } ctrl_st_e;
endpackage

// File: rtl/cache_wbuf.sv
// FIFO of evicted lines; lookup reports the newest matching entry.
module cache_wbuf #(
  parameter int unsigned LA_W   = 28,
  parameter int unsigned DATA_W = 128,
  parameter int unsigned DEPTH  = 4    // power of two, >= 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [LA_W-1:0]   push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic [LA_W-1:0]   look_addr_i,
  output logic              look_hit_o,
  output logic [DATA_W-1:0] look_data_o,
  output logic [LA_W-1:0]   head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic [LA_W-1:0]   addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PW-1:0]     rd_q, wr_q;
  logic [CW-1:0]     cnt_q;

  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[rd_q];
  assign head_data_o = data_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_q] <= push_addr_i;
      data_q[wr_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  // scan oldest to newest, so the last match wins
  always_comb begin
    logic [PW-1:0] slot;
    look_hit_o  = 1'b0;
    look_data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = rd_q + PW'(k);
      if ((CW'(k) < cnt_q) && (addr_q[slot] == look_addr_i)) begin
        look_hit_o  = 1'b1;
        look_data_o = data_q[slot];
      end
    end
  end
endmodule

// File: rtl/cache_store.sv
// Tag, state and data arrays of the direct-mapped cache.
module cache_store #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned TAG_W     = 22,
  parameter int unsigned LINE_W    = 128
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(NUM_LINES)-1:0] rd_idx_i,
  output logic                         rd_valid_o,
  output logic                         rd_dirty_o,
  output logic [TAG_W-1:0]             rd_tag_o,
  output logic [LINE_W-1:0]            rd_line_o,
  input  logic                         fill_i,
  input  logic [$clog2(NUM_LINES)-1:0] fill_idx_i,
  input  logic [TAG_W-1:0]             fill_tag_i,
  input  logic [LINE_W-1:0]            fill_line_i,
  input  logic                         inval_i,
  input  logic                         wr_i,
  input  logic [$clog2(LINE_W/32)-1:0] wr_word_i,
  input  logic [3:0]                   wr_be_i,
  input  logic [31:0]                  wr_data_i
);
  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [LINE_W-1:0]    data_q [NUM_LINES];

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_line_o  = data_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[fill_idx_i] <= 1'b1;
      dirty_q[fill_idx_i] <= 1'b0;
    end else if (inval_i) begin
      valid_q[rd_idx_i] <= 1'b0;
      dirty_q[rd_idx_i] <= 1'b0;
    end else if (wr_i) begin
      dirty_q[rd_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[fill_idx_i]  <= fill_tag_i;
      data_q[fill_idx_i] <= fill_line_i;
    end else if (wr_i) begin
      for (int b = 0; b < 4; b++) begin
        if (wr_be_i[b])
          data_q[rd_idx_i][32*int'(wr_word_i) + 8*b +: 8] <= wr_data_i[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import cache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned NUM_LINES  = 64,
  parameter int unsigned WB_DEPTH   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cpu_req_i,
  input  logic                      cpu_we_i,
  input  logic [ADDR_W-1:0]         cpu_addr_i,
  input  logic [3:0]                cpu_be_i,
  input  logic [31:0]               cpu_wdata_i,
  output logic [31:0]               cpu_rdata_o,
  output logic                      cpu_stall_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [8*LINE_BYTES-1:0]   mem_wdata_o,
  input  logic [8*LINE_BYTES-1:0]   mem_rdata_i,
  input  logic                      mem_ack_i
);
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W  = $clog2(NUM_LINES);
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int unsigned LA_W   = ADDR_W - OFF_W;
  localparam int unsigned LINE_W = 8 * LINE_BYTES;
  localparam int unsigned WSEL_W = $clog2(LINE_BYTES / 4);

  // address split
  logic [LA_W-1:0]   a_line;
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  logic [WSEL_W-1:0] a_word;
  assign a_line = cpu_addr_i[ADDR_W-1:OFF_W];
  assign a_idx  = cpu_addr_i[OFF_W +: IDX_W];
  assign a_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign a_word = cpu_addr_i[OFF_W-1:2];

  ctrl_st_e        st_q;
  logic [LA_W-1:0] fill_line_q;
  logic            busy_q, fill_own_q;

  logic              line_valid, line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [LINE_W-1:0] line_data;
  logic              hit, victim_dirty;

  logic              wb_push, wb_pop, wb_full, wb_empty, wb_look_hit;
  logic [LINE_W-1:0] wb_look_data, wb_head_data;
  logic [LA_W-1:0]   wb_head_addr;

  logic              st_fill, st_inval, st_wr, fwd, go_fill;
  logic              fill_start, fill_done;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [LINE_W-1:0] fill_data;

  cache_store #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W),
    .LINE_W    (LINE_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (a_idx),
    .rd_valid_o  (line_valid),
    .rd_dirty_o  (line_dirty),
    .rd_tag_o    (line_tag),
    .rd_line_o   (line_data),
    .fill_i      (st_fill),
    .fill_idx_i  (fill_idx),
    .fill_tag_i  (fill_tag),
    .fill_line_i (fill_data),
    .inval_i     (st_inval),
    .wr_i        (st_wr),
    .wr_word_i   (a_word),
    .wr_be_i     (cpu_be_i),
    .wr_data_i   (cpu_wdata_i)
  );

  cache_wbuf #(
    .LA_W   (LA_W),
    .DATA_W (LINE_W),
    .DEPTH  (WB_DEPTH)
  ) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wb_push),
    .push_addr_i ({line_tag, a_idx}),
    .push_data_i (line_data),
    .pop_i       (wb_pop),
    .look_addr_i (a_line),
    .look_hit_o  (wb_look_hit),
    .look_data_o (wb_look_data),
    .head_addr_o (wb_head_addr),
    .head_data_o (wb_head_data),
    .full_o      (wb_full),
    .empty_o     (wb_empty)
  );

  assign hit          = (st_q == ST_LOOKUP) && line_valid && (line_tag == a_tag);
  assign victim_dirty = line_valid && line_dirty;
  assign cpu_stall_o  = cpu_req_i && !hit;
  assign cpu_rdata_o  = line_data[32*int'(a_word) +: 32];

  always_comb begin
    wb_push  = 1'b0;
    fwd      = 1'b0;
    go_fill  = 1'b0;
    st_inval = 1'b0;
    st_wr    = 1'b0;
    if (st_q == ST_LOOKUP && cpu_req_i) begin
      if (hit) begin
        st_wr = cpu_we_i;
      end else if (!(victim_dirty && wb_full)) begin
        wb_push = victim_dirty;
        if (wb_look_hit) begin
          fwd = 1'b1;
        end else begin
          go_fill  = 1'b1;
          st_inval = line_valid;
        end
      end
    end
  end

  // memory port: fill wins over drain when the port is free
  assign fill_start = !busy_q && (st_q == ST_FILL);
  assign fill_done  = busy_q && fill_own_q && mem_ack_i;
  assign wb_pop     = busy_q && !fill_own_q && mem_ack_i;

  assign st_fill   = fwd || fill_done;
  assign fill_idx  = fill_done ? fill_line_q[IDX_W-1:0] : a_idx;
  assign fill_tag  = fill_done ? fill_line_q[LA_W-1 -: TAG_W] : a_tag;
  assign fill_data = fill_done ? mem_rdata_i : wb_look_data;

  assign mem_req_o   = busy_q;
  assign mem_we_o    = busy_q && !fill_own_q;
  assign mem_addr_o  = {(fill_own_q ? fill_line_q : wb_head_addr), {OFF_W{1'b0}}};
  assign mem_wdata_o = wb_head_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_LOOKUP;
      fill_line_q <= '0;
    end else if (go_fill) begin
      st_q        <= ST_FILL;
      fill_line_q <= a_line;
    end else if (fill_done) begin
      st_q <= ST_LOOKUP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      fill_own_q <= 1'b0;
    end else if (!busy_q) begin
      if (st_q == ST_FILL) begin
        busy_q     <= 1'b1;
        fill_own_q <= 1'b1;
      end else if (!wb_empty) begin
        busy_q     <= 1'b1;
        fill_own_q <= 1'b0;
      end
    end else if (mem_ack_i) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_stall_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LINE_W-1:0] mem_wdata_o,
  input logic              wb_push,
  input logic              wb_full,
  input logic              wb_empty,
  input logic              fill_start,
  input logic              fill_done
);
  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && (!mem_we_o || $stable(mem_wdata_o))));

  // R8
  push_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_push |-> !wb_full);

  // R9
  fill_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_start |=> (mem_req_o && !mem_we_o));

  // R5
  fill_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> (!cpu_req_i || !cpu_stall_o));

  // R7
  drain_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !wb_empty);
endmodule

bind dm_wb_cache dm_wb_cache_chk #(
  .ADDR_W (ADDR_W),
  .LINE_W (LINE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_stall_o (cpu_stall_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .wb_push     (wb_push),
  .wb_full     (wb_full),
  .wb_empty    (wb_empty),
  .fill_start  (fill_start),
  .fill_done   (fill_done)
);

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [31:0]  cpu_addr_i = '0, cpu_wdata_i = '0;
  logic [3:0]   cpu_be_i = '0;
  logic [31:0]  cpu_rdata_o;
  logic         cpu_stall_o;
  logic         mem_req_o, mem_we_o;
  logic [31:0]  mem_addr_o;
  logic [127:0] mem_wdata_o;
  logic [127:0] mem_rdata_i = '0;
  logic         mem_ack_i = 1'b0;

  always #4 clk_i = ~clk_i;

  dm_wb_cache u_dm_wb_cache (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_be_i(cpu_be_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .cpu_stall_o(cpu_stall_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  int n_chk = 0, n_fail = 0;
  int rd_lat = 2, wr_lat = 2;
  int n_rd = 0, n_wr = 0;
  logic [31:0]  last_rd_addr, last_wr_addr;
  logic [127:0] last_wr_data;
  bit  watch = 0, first_seen = 0, first_we = 0;
  bit  done = 0;

  bit [127:0] lmem [bit [31:0]];
  bit [31:0]  rmem [bit [31:0]];

  function automatic bit [31:0] init_word(bit [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic bit [127:0] lmem_read(bit [31:0] a);
    bit [127:0] l;
    if (lmem.exists(a)) return lmem[a];
    for (int w = 0; w < 4; w++) l[32*w +: 32] = init_word(a + 32'(4*w));
    return l;
  endfunction

  function automatic bit [31:0] ref_read(bit [31:0] a);
    bit [31:0] wa = {a[31:2], 2'b00};
    return rmem.exists(wa) ? rmem[wa] : init_word(wa);
  endfunction

  function automatic void ref_write(bit [31:0] a, bit [31:0] d, bit [3:0] be);
    bit [31:0] w = ref_read(a);
    for (int b = 0; b < 4; b++) if (be[b]) w[8*b +: 8] = d[8*b +: 8];
    rmem[{a[31:2], 2'b00}] = w;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
        cnt = 0;
      end else if (mem_req_o) begin
        if (cnt == 0 && watch && !first_seen) begin
          first_seen = 1;
          first_we   = mem_we_o;
        end
        cnt++;
        if (cnt >= (mem_we_o ? wr_lat : rd_lat)) begin
          mem_ack_i = 1'b1;
          if (mem_we_o) begin
            lmem[mem_addr_o] = mem_wdata_o;
            last_wr_addr = mem_addr_o;
            last_wr_data = mem_wdata_o;
            n_wr++;
          end else begin
            mem_rdata_i  = lmem_read(mem_addr_o);
            last_rd_addr = mem_addr_o;
            n_rd++;
          end
        end
      end
    end
  end

  task automatic access(bit we, bit [31:0] a, bit [31:0] wd, bit [3:0] be,
                        output bit [31:0] rd, output int stalls);
    @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = wd; cpu_be_i = be;
    stalls = 0;
    #1;
    while (cpu_stall_o) begin
      @(negedge clk_i); #1;
      stalls++;
    end
    rd = cpu_rdata_o;
    if (we) ref_write(a, wd, be);
    @(posedge clk_i); #1;
    cpu_req_i = 1'b0;
  endtask

  task automatic rd_chk(bit [31:0] a, string req);
    bit [31:0] rd; int s;
    access(0, a, '0, '0, rd, s);
    chk(rd == ref_read(a), req, rd, ref_read(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [31:0] rd; int s, r0, w0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R2 reset state
    chk(!cpu_stall_o && !mem_req_o, "R2 idle after reset", {cpu_stall_o, mem_req_o}, 0);

    // R2 R5 R1 cold read, offset ignored for memory address
    r0 = n_rd;
    access(0, 32'h48, '0, '0, rd, s);
    chk(s > 0 && n_rd == r0 + 1, "R2 cold miss stalls and reads", s, 1);
    chk(last_rd_addr == 32'h40, "R5 line-aligned fill", last_rd_addr, 32'h40);
    chk(rd == ref_read(32'h48), "R5 miss data", rd, ref_read(32'h48));

    // R3 hit
    r0 = n_rd;
    access(0, 32'h44, '0, '0, rd, s);
    chk(s == 0 && n_rd == r0, "R3 hit no stall", s, 0);
    chk(rd == ref_read(32'h44), "R3 hit data", rd, ref_read(32'h44));

    // R4 byte-enable store hit
    w0 = n_wr;
    access(1, 32'h44, 32'hAABB_CCDD, 4'b0101, rd, s);
    chk(s == 0, "R4 store hit no stall", s, 0);
    rd_chk(32'h44, "R4 byte merge");
    idle(5);
    chk(n_wr == w0, "R4 no memory write", n_wr, w0);

    // R6 store miss
    r0 = n_rd;
    access(1, 32'h80, 32'h1234_5678, 4'b0011, rd, s);
    chk(s > 0 && n_rd == r0 + 1, "R6 store miss fetches", n_rd, r0 + 1);
    rd_chk(32'h80, "R6 merged word");
    rd_chk(32'h84, "R6 untouched word");

    // R1 R9 R7 conflict evicts dirty line at index 4
    watch = 1; first_seen = 0;
    w0 = n_wr;
    access(0, 32'h440, '0, '0, rd, s);
    watch = 0;
    chk(s > 0, "R1 same index other tag misses", s, 1);
    chk(first_seen && !first_we, "R9 fill before drain", first_we, 0);
    idle(10);
    chk(n_wr == w0 + 1 && last_wr_addr == 32'h40, "R7 victim written", last_wr_addr, 32'h40);
    chk(last_wr_data[63:32] == ref_read(32'h44), "R7 victim data", last_wr_data[63:32], ref_read(32'h44));

    // R7 clean eviction
    w0 = n_wr;
    access(0, 32'h840, '0, '0, rd, s);
    idle(10);
    chk(n_wr == w0, "R7 clean victim dropped", n_wr, w0);

    // R10 R8 ping-pong through the write buffer with slow writes
    wr_lat = 60;
    access(1, 32'h100, 32'h0000_0001, 4'hF, rd, s);
    access(1, 32'h500, 32'h0000_0002, 4'hF, rd, s);
    r0 = n_rd;
    access(1, 32'h104, 32'h0000_0003, 4'hF, rd, s);
    access(1, 32'h504, 32'h0000_0004, 4'hF, rd, s);
    access(1, 32'h108, 32'h0000_0005, 4'hF, rd, s);
    chk(n_rd == r0, "R10 served from buffer", n_rd, r0);
    w0 = n_wr;
    access(1, 32'h508, 32'h0000_0006, 4'hF, rd, s);
    chk(s > 5 && n_wr > w0, "R8 full buffer waits for drain", s, 6);
    chk(n_rd == r0, "R10 no memory read", n_rd, r0);
    wr_lat = 2;
    rd_chk(32'h100, "R10 newest X");
    rd_chk(32'h104, "R10 newest X");
    rd_chk(32'h108, "R10 newest X");
    rd_chk(32'h500, "R10 newest Y");
    rd_chk(32'h504, "R10 newest Y");
    rd_chk(32'h508, "R10 newest Y");

    // random traffic over conflicting lines
    for (int i = 0; i < 2000; i++) begin
      bit [31:0] a;
      a = ($urandom % 4) << 10 | ($urandom % 4) << 4 | ($urandom % 4) << 2;
      rd_lat = 1 + $urandom % 4;
      wr_lat = 1 + $urandom % 4;
      if ($urandom % 2) access(1, a, $urandom, 4'($urandom), rd, s);
      else rd_chk(a, "R3 R5 random read");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule